// File: doc/BRIEF.md
# General-Purpose Output Port with Bit Set/Clear Control

This block is an eight-pin general-purpose output port. Its driven state is held in an output register. Software never writes that register as a whole. One write strobe sets the bits marked with a one, and a second strobe clears the bits marked with a one. Several agents can therefore change their own pins without a read-modify-write sequence.

Each pin is driven active-low. A register bit at one pulls its pin low.

A separately written routing byte lets each of the upper six pins carry an internal signal instead of its register bit. The internal signals are:
- transmitter ready and receiver ready/full for two serial channels;
- a counter/timer output;
- several transmit and receive clocks.

These signals arrive as inputs, and the block only selects among them. Pins 1 and 0 always show their register bits.

Top module: `gpo_port`

## Requirements
- R1: After a synchronous active-low reset, the output register and the routing byte are all zeros, so every pin is high (pin_n = 8'hFF) whatever the alternate inputs are.
- R2: A cycle with set_we high changes every output register bit whose set_data bit is 1 to 1 and leaves the other bits unchanged; the effect is visible on the pins right after that clock edge.
- R3: A cycle with clr_we high changes every output register bit whose clr_data bit is 1 to 0 and leaves the other bits unchanged.
- R4: When set_we and clr_we are both high in the same cycle, a bit marked in both clears; bits marked in only one of them are set or cleared as usual.
- R5: With neither set_we nor clr_we high, the output register holds, even if set_data and clr_data change.
- R6: A pin routed to its register bit is driven to the inverse of that bit (1 gives low, 0 gives high).
- R7: Routing bit 7 = 1 drives pin 7 with the inverse of tx_rdy_b. Routing bit 6 = 1 drives pin 6 with the inverse of tx_rdy_a. A routing bit of 0 selects the register bit.
- R8: Routing bit 5 = 1 drives pin 5 with the inverse of rx_rdy_b. Routing bit 4 = 1 drives pin 4 with the inverse of rx_rdy_a.
- R9: Routing bits 3:2 pick the source of pin 3: 00 selects the register bit, 01 selects ct_out, 10 selects tx_clk1_b and 11 selects rx_clk1_b. The pin carries the inverse of the selected source.
- R10: Routing bits 1:0 pick the source of pin 2: 00 selects the register bit, 01 selects tx_clk16_a, 10 selects tx_clk1_a and 11 selects rx_clk1_a. The pin carries the inverse of the selected source.
- R11: Pins 1 and 0 always carry the inverse of their register bits, whatever the routing byte holds.
- R12: The routing byte loads from cfg_data on a cycle with cfg_we high and takes effect right after that edge. While a pin is routed away, its register bit keeps being updated by the strobes, and it reappears on the pin when the routing returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_we | input | 1 | Set strobe |
| set_data | input | 8 | Bits to set on set_we |
| clr_we | input | 1 | Clear strobe |
| clr_data | input | 8 | Bits to clear on clr_we |
| cfg_we | input | 1 | Routing byte write strobe |
| cfg_data | input | 8 | Routing byte value |
| tx_rdy_a | input | 1 | Channel A transmitter ready |
| tx_rdy_b | input | 1 | Channel B transmitter ready |
| rx_rdy_a | input | 1 | Channel A receiver ready/full |
| rx_rdy_b | input | 1 | Channel B receiver ready/full |
| ct_out | input | 1 | Counter/timer output |
| tx_clk16_a | input | 1 | Channel A 16x transmit clock |
| tx_clk1_a | input | 1 | Channel A 1x transmit clock |
| rx_clk1_a | input | 1 | Channel A 1x receive clock |
| tx_clk1_b | input | 1 | Channel B 1x transmit clock |
| rx_clk1_b | input | 1 | Channel B 1x receive clock |
| pin_n | output | 8 | Output pins, active low |

## Verification
The set strobe and the clear strobe can arrive in the same cycle. The stimulus provokes this both with overlapping masks and with disjoint masks, in directed cases and in random cycles where both enables are drawn independently. A bench model applies the set first and then the clear, and every pin is compared against that model after each edge. A routing-byte write is also mixed into those cycles, so that the new routing and the register update land on the same edge and must both show on the next comparison.

// File: rtl/gpo_pkg.sv
// Package: shared constants and types for the output port.
// Assumes an eight-pin port whose upper six pins can be rerouted.
package gpo_pkg;
    localparam int PIN_W    = 8;
    localparam int FIXED_LO = 2;   // pins below this index never reroute

    // Source code for the two pins with four-way routing.
    typedef enum logic [1:0] {
        SRC_REG  = 2'b00,
        SRC_ALT1 = 2'b01,
        SRC_ALT2 = 2'b10,
        SRC_ALT3 = 2'b11
    } quad_sel_e;

    // Bundle of internal alternate signals.
    typedef struct packed {
        logic tx_rdy_b;
        logic tx_rdy_a;
        logic rx_rdy_b;
        logic rx_rdy_a;
        logic ct_out;
        logic tx_clk1_b;
        logic rx_clk1_b;
        logic tx_clk16_a;
        logic tx_clk1_a;
        logic rx_clk1_a;
    } alt_src_t;
endpackage

// File: rtl/gpo_setclr_reg.sv
// Module: output register changed only through set and clear strobes.
// Assumes synchronous active-low reset. When both strobes hit the same bit, the clear wins.
module gpo_setclr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_data,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;
    logic [W-1:0] q_next;

    // Purpose: gate each data byte with its strobe.
    always_comb begin
        set_mask = set_we ? set_data : '0;
        clr_mask = clr_we ? clr_data : '0;
    end

    // Purpose: apply the set, then the clear, so the clear has priority.
    always_comb begin
        q_next = (q | set_mask) & ~clr_mask;
    end

    // Purpose: hold the register; reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/gpo_cfg_reg.sv
// Module: routing byte register that is loaded whole on its write strobe.
// Assumes synchronous active-low reset to all zeros, which selects register bits everywhere.
module gpo_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: load on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/gpo_pin_mux.sv
// Module: chooses the source of each pin and drives it inverted.
// Assumes the fixed layout: pins 7..4 have a two-way choice, pins 3 and 2 have a four-way choice,
// and pins 1..0 are fixed to their register bits.
module gpo_pin_mux
    import gpo_pkg::*;
(
    input  logic [PIN_W-1:0] reg_q,
    input  logic [PIN_W-1:0] cfg_q,
    input  alt_src_t         alt,
    output logic [PIN_W-1:0] pin_n
);
    localparam int SINGLE_LO = 4;

    logic [PIN_W-1:0] src;
    logic [PIN_W-1:SINGLE_LO] single_alt;
    quad_sel_e sel3;
    quad_sel_e sel2;

    // Purpose: order the two-way alternates by pin index.
    always_comb begin
        single_alt = {alt.tx_rdy_b, alt.tx_rdy_a, alt.rx_rdy_b, alt.rx_rdy_a};
    end

    // Purpose: decode the two four-way routing fields.
    always_comb begin
        sel3 = quad_sel_e'(cfg_q[3:2]);
        sel2 = quad_sel_e'(cfg_q[1:0]);
    end

    genvar gi;
    generate
        for (gi = SINGLE_LO; gi < PIN_W; gi++) begin : g_two_way
            // Purpose: the routing bit picks either the alternate or the register bit.
            always_comb begin
                src[gi] = cfg_q[gi] ? single_alt[gi] : reg_q[gi];
            end
        end
        for (gi = 0; gi < FIXED_LO; gi++) begin : g_fixed
            // Purpose: the low pins always follow the register.
            always_comb begin
                src[gi] = reg_q[gi];
            end
        end
    endgenerate

    // Purpose: four-way choice for pin 3.
    always_comb begin
        unique case (sel3)
            SRC_REG:  src[3] = reg_q[3];
            SRC_ALT1: src[3] = alt.ct_out;
            SRC_ALT2: src[3] = alt.tx_clk1_b;
            default:  src[3] = alt.rx_clk1_b;
        endcase
    end

    // Purpose: four-way choice for pin 2.
    always_comb begin
        unique case (sel2)
            SRC_REG:  src[2] = reg_q[2];
            SRC_ALT1: src[2] = alt.tx_clk16_a;
            SRC_ALT2: src[2] = alt.tx_clk1_a;
            default:  src[2] = alt.rx_clk1_a;
        endcase
    end

    // Purpose: the pins are active low.
    always_comb begin
        pin_n = ~src;
    end
endmodule

// File: rtl/gpo_port.sv
// Module: top of the general-purpose output port.
// Assumes synchronous active-low reset, and alternate sources that are already synchronous to clk.
module gpo_port
    import gpo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_we,
    input  logic [7:0] set_data,
    input  logic       clr_we,
    input  logic [7:0] clr_data,
    input  logic       cfg_we,
    input  logic [7:0] cfg_data,
    input  logic       tx_rdy_a,
    input  logic       tx_rdy_b,
    input  logic       rx_rdy_a,
    input  logic       rx_rdy_b,
    input  logic       ct_out,
    input  logic       tx_clk16_a,
    input  logic       tx_clk1_a,
    input  logic       rx_clk1_a,
    input  logic       tx_clk1_b,
    input  logic       rx_clk1_b,
    output logic [7:0] pin_n
);
    logic [PIN_W-1:0] reg_q;
    logic [PIN_W-1:0] cfg_q;
    alt_src_t         alt;

    // Purpose: gather the alternate inputs into one bundle.
    always_comb begin
        alt.tx_rdy_b   = tx_rdy_b;
        alt.tx_rdy_a   = tx_rdy_a;
        alt.rx_rdy_b   = rx_rdy_b;
        alt.rx_rdy_a   = rx_rdy_a;
        alt.ct_out     = ct_out;
        alt.tx_clk1_b  = tx_clk1_b;
        alt.rx_clk1_b  = rx_clk1_b;
        alt.tx_clk16_a = tx_clk16_a;
        alt.tx_clk1_a  = tx_clk1_a;
        alt.rx_clk1_a  = rx_clk1_a;
    end

    gpo_setclr_reg #(.W(PIN_W)) i_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .set_data (set_data),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .q        (reg_q)
    );

    gpo_cfg_reg #(.W(PIN_W)) i_cfgreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .d     (cfg_data),
        .q     (cfg_q)
    );

    gpo_pin_mux i_mux (
        .reg_q (reg_q),
        .cfg_q (cfg_q),
        .alt   (alt),
        .pin_n (pin_n)
    );
endmodule

// File: rtl/gpo_port_chk.sv
// Checker: properties of the output port, bound into every gpo_port instance.
module gpo_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_we,
    input logic [7:0] set_data,
    input logic       clr_we,
    input logic [7:0] clr_data,
    input logic       cfg_we,
    input logic [7:0] cfg_data,
    input logic       tx_rdy_a,
    input logic       tx_rdy_b,
    input logic [7:0] reg_q,
    input logic [7:0] cfg_q,
    input logic [7:0] pin_n
);
    // R2, R4: bits set and not cleared in the same cycle read 1 afterwards.
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((reg_q & ($past(set_data) & ~($past(clr_we) ? $past(clr_data) : 8'h00)))
                    == ($past(set_data) & ~($past(clr_we) ? $past(clr_data) : 8'h00))));

    // R3, R4: cleared bits read 0 afterwards, even when also set.
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((reg_q & $past(clr_data)) == 8'h00));

    // R5: no strobe, no change.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(reg_q));

    // R11: low pins follow the register.
    assert_fixed_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_n[1:0] == ~reg_q[1:0]);

    // R7: pin 7 and pin 6 alternates.
    assert_pin7_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |-> (pin_n[7] == ~tx_rdy_b));
    assert_pin6_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6] |-> (pin_n[6] == ~tx_rdy_a));

    // R12: routing byte loads on its strobe.
    assert_cfg_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_data)));
    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

bind gpo_port gpo_port_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .tx_rdy_a (tx_rdy_a),
    .tx_rdy_b (tx_rdy_b),
    .reg_q    (reg_q),
    .cfg_q    (cfg_q),
    .pin_n    (pin_n)
);

// File: tb/test_gpo_port.sv
module test_gpo_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_we = 1'b0;
    logic [7:0] set_data = '0;
    logic       clr_we = 1'b0;
    logic [7:0] clr_data = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic [9:0] altv = '0;  // {tx_rdy_b,tx_rdy_a,rx_rdy_b,rx_rdy_a,ct,txc1b,rxc1b,txc16a,txc1a,rxc1a}
    logic [7:0] pin_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_reg = '0;
    logic [7:0] m_cfg = '0;
    int unsigned seed_v;

    always #4 clk = ~clk;  // 125 MHz

    gpo_port i_gpo_port (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data),
        .cfg_we(cfg_we), .cfg_data(cfg_data),
        .tx_rdy_b(altv[9]), .tx_rdy_a(altv[8]),
        .rx_rdy_b(altv[7]), .rx_rdy_a(altv[6]),
        .ct_out(altv[5]), .tx_clk1_b(altv[4]), .rx_clk1_b(altv[3]),
        .tx_clk16_a(altv[2]), .tx_clk1_a(altv[1]), .rx_clk1_a(altv[0]),
        .pin_n(pin_n)
    );

    // Expected pins from the requirements.
    function automatic logic [7:0] exp_pins(logic [7:0] r, logic [7:0] c, logic [9:0] a);
        logic [7:0] s;
        s = r;
        if (c[7]) s[7] = a[9];
        if (c[6]) s[6] = a[8];
        if (c[5]) s[5] = a[7];
        if (c[4]) s[4] = a[6];
        case (c[3:2])
            2'b01: s[3] = a[5];
            2'b10: s[3] = a[4];
            2'b11: s[3] = a[3];
            default: s[3] = r[3];
        endcase
        case (c[1:0])
            2'b01: s[2] = a[2];
            2'b10: s[2] = a[1];
            2'b11: s[2] = a[0];
            default: s[2] = r[2];
        endcase
        return ~s;
    endfunction

    task automatic check(string tag, logic [7:0] exp);
        checks++;
        if (pin_n !== exp) begin
            errors++;
            $display("FAIL %s pin_n got %h expected %h", tag, pin_n, exp);
        end
    endtask

    // One cycle: drive at negedge, model update at posedge, check 2 ns later.
    task automatic cyc(string tag, logic sw, logic [7:0] sd, logic cw, logic [7:0] cd,
                       logic fw, logic [7:0] fd, logic [9:0] a);
        @(negedge clk);
        set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
        cfg_we = fw; cfg_data = fd; altv = a;
        @(posedge clk);
        if (!rst_n) begin
            m_reg = '0; m_cfg = '0;
        end else begin
            m_reg = (m_reg | (sw ? sd : 8'h00)) & ~(cw ? cd : 8'h00);
            if (fw) m_cfg = fd;
        end
        #2;
        check(tag, exp_pins(m_reg, m_cfg, altv));
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        seed_v = 32'd12345;
        void'($urandom(seed_v));
        rst_n = 1'b0;
        // R1: reset with writes and alternate inputs active
        cyc("R1", 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1, 8'hFF, 10'h3FF);
        check("R1", 8'hFF);
        cyc("R1", 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 10'h3FF);
        rst_n = 1'b1;
        // R2, R6: set some bits
        cyc("R2", 1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 8'h00, 10'h000);
        check("R6", 8'h5A);
        cyc("R2", 1'b1, 8'h0A, 1'b0, 8'h00, 1'b0, 8'h00, 10'h000);
        // R3: clear some bits
        cyc("R3", 1'b0, 8'h00, 1'b1, 8'h81, 1'b0, 8'h00, 10'h000);
        check("R3", ~8'h2E);
        // R5: data changes without strobes
        cyc("R5", 1'b0, 8'hFF, 1'b0, 8'hFF, 1'b0, 8'h00, 10'h000);
        check("R5", ~8'h2E);
        // R4: overlap clears, disjoint bits act
        cyc("R4", 1'b1, 8'hF0, 1'b1, 8'h3C, 1'b0, 8'h00, 10'h000);
        check("R4", ~8'hC2);
        // R11: route everything away, low pins still follow register
        cyc("R11", 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'hFF, 10'h000);
        check("R11", {6'h3F, ~2'b10});
        // R7, R8: two-way alternates follow their inputs
        for (int k = 0; k < 16; k++) begin
            cyc("R7_R8", 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'hF0, {k[3:0], 6'h00});
        end
        // R9, R10: every code of both four-way fields with each alternate toggled
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 64; a += 21) begin
                cyc("R9_R10", 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, {4'h0, c[3:0]},
                    {4'h0, a[5:0]});
            end
        end
        // R12: register updates while routed away, visible when routing returns
        cyc("R12", 1'b1, 8'hF0, 1'b0, 8'h00, 1'b1, 8'hFF, 10'h000);
        cyc("R12", 1'b0, 8'h00, 1'b1, 8'h30, 1'b0, 8'h00, 10'h3FF);
        cyc("R12", 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 10'h3FF);
        check("R12", ~8'hC2);
        // Random mix: strobes, routing and alternates in the same cycle (R2 R3 R4 R12)
        for (int i = 0; i < 3000; i++) begin
            cyc("R4_rand", 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
                ($urandom % 4) == 0, 8'($urandom), 10'($urandom));
        end
        // R1: reset mid-run
        rst_n = 1'b0;
        cyc("R1", 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 10'h3FF);
        check("R1", 8'hFF);
        rst_n = 1'b1;
        cyc("R1", 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 10'h3FF);
        check("R1", 8'hFF);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule